// File: doc/BRIEF.md
# Byte-Wide SPI Master with Register Interface

This block is a register-programmed SPI master that moves one byte at a time. Software picks the clock polarity, the clock phase, the bit order and the interrupt enable in a control register. It sets an even clock divider, then writes a byte to the data register. That write shifts eight bits out on `mosi` while eight bits are captured from `miso`. When the byte is done, a completion flag rises in the status register and an interrupt flag is set. The interrupt flag drives `irq` when interrupts are enabled.

Errors are flagged rather than acted on, with one exception:
- A data write during a transfer is dropped and marked as a collision.
- A byte that completes while the previous completion is still unacknowledged is marked as an overrun.
- A select input driven low while the block is master is a mode fault. It aborts the transfer and drops the master bit.

The register port is a plain single-cycle strobe interface with no back-pressure. A write or a read takes effect on the clock edge where its strobe is high, and `reg_rdata` shows the addressed register combinationally. `ssel_n` is taken to be synchronous to `clk`.

Top module: `spi_byte_master`

## Requirements
- R1: After reset the registers read as follows: control (address 0) 0x00, status (address 1) 0x00, divider (address 3) 8, interrupt flag (address 4) 0x00. `irq` and `sck` are low.
- R2: A write to the divider register (address 3) stores the value with bit 0 forced to 0. Any value below 8 is stored as 8. A read returns the stored value.
- R3: A data-register write (address 2) starts one 8-bit transfer when control bit 5 (master) is 1 and the engine is idle. Each SCK level lasts divider/2 clocks. Status bit 7 (complete) reads 1 from 16*(divider/2)+1 cycles after the write edge, and 0 one cycle earlier.
- R4: While idle, `sck` rests at control bit 4 (polarity). With control bit 3 (phase) at 0, both sides sample on the first, third and later odd SCK edges. With phase at 1, both sides sample on the even edges. A transfer makes exactly 16 SCK edges.
- R5: Control bit 6 at 1 sends and receives least significant bit first; at 0, most significant bit first.
- R6: Reading the data register returns the byte received in the last completed transfer.
- R7: A data write while a transfer is running is ignored: the byte on `mosi` is unchanged. It sets status bit 6 (collision).
- R8: When a transfer completes while status bit 7 is still 1, status bit 5 (overrun) is set, and the data register takes the new byte.
- R9: A status read with bit 7, 6 or 5 set, followed by a data-register access, clears those three bits. A data access without that preceding status read leaves them set.
- R10: `ssel_n` low while master is set causes a mode fault:
  - status bit 4 is set;
  - control bit 5 is cleared;
  - any transfer is aborted without completion.

  Bit 4 clears only on a control write that follows a status read which saw it.
- R11: Interrupt-flag bit 0 is set on each completion and on each mode fault. `irq` equals that bit ANDed with control bit 7. Writing 1 to bit 0 clears it; writing 0 has no effect.
- R12: With control bit 5 at 0 (for example after writing 0x00), a data write starts nothing and `sck` does not toggle. Clearing bit 5 during a transfer aborts it without completion. Status bit 3 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (needed for the flag-clearing sequences) |
| reg_addr | input | 3 | Register address: 0 control, 1 status, 2 data, 3 divider, 4 interrupt flag |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| irq | output | 1 | Interrupt request |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ssel_n | input | 1 | Select input watched for mode fault |

## Verification
The latency of each result is fixed:
- The interrupt flag and `irq` rise together with the complete flag, 16*(divider/2)+1 cycles after the data-write edge.
- The complete flag is confirmed clear exactly one cycle before that point, so an off-by-one in the divider or the edge count is caught.
- A collision, a flag clear or a mode fault shows on the cycle after its causing edge.

The bench reads every result by peeking the status and control registers one time unit after the clock edge where it is due. The expected bytes come from a bench-side slave model that counts SCK edges. The sampled `mosi` bits are rebuilt in the order the mode requires.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;
  typedef enum logic [2:0] {
    RA_CTRL  = 3'd0,
    RA_STAT  = 3'd1,
    RA_DATA  = 3'd2,
    RA_DIV   = 3'd3,
    RA_IFLAG = 3'd4
  } reg_addr_e;

  // control bit positions
  localparam int unsigned CB_IE   = 7;
  localparam int unsigned CB_LSBF = 6;
  localparam int unsigned CB_MSTR = 5;
  localparam int unsigned CB_CPOL = 4;
  localparam int unsigned CB_CPHA = 3;

  typedef struct packed {
    logic ie;
    logic lsbf;
    logic master;
    logic cpol;
    logic cpha;
  } ctrl_t;
endpackage

// File: rtl/spi_sck_timer.sv
module spi_sck_timer #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] half,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q;

  assign tick = run && (cnt_q == half - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt_q <= '0;
    else if (!run || tick) cnt_q <= '0;
    else                  cnt_q <= cnt_q + CNT_W'(1);
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R3
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              lsbf,
  input  logic              tick,
  input  logic              miso,
  output logic              busy,
  output logic              sck,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_byte,
  output logic              done
);
  localparam int unsigned EDGES = 2 * DATA_W;
  localparam int unsigned EC_W  = $clog2(EDGES);
  localparam logic [EC_W-1:0] EC_LAST = EC_W'(EDGES - 1);

  logic              busy_q, sck_q, done_q;
  logic [DATA_W-1:0] tx_q, rx_q, rx_next;
  logic [EC_W-1:0]   ec_q;
  logic              samp_edge;

  // even edge index = leading edge; phase picks which one samples
  assign samp_edge = (~ec_q[0]) ^ cpha;
  assign rx_next   = lsbf ? {miso, rx_q[DATA_W-1:1]} : {rx_q[DATA_W-2:0], miso};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
      ec_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (abort) begin
        busy_q <= 1'b0;
        sck_q  <= cpol;
      end else if (start) begin
        busy_q <= 1'b1;
        tx_q   <= tx_byte;
        ec_q   <= '0;
        sck_q  <= cpol;
      end else if (busy_q && tick) begin
        sck_q <= ~sck_q;
        ec_q  <= ec_q + EC_W'(1);
        if (samp_edge)
          rx_q <= rx_next;
        else if (ec_q != '0)
          tx_q <= lsbf ? (tx_q >> 1) : (tx_q << 1);
        if (ec_q == EC_LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else if (!busy_q) begin
        sck_q <= cpol;
      end
    end
  end

  assign busy    = busy_q;
  assign sck     = sck_q;
  assign done    = done_q;
  assign rx_byte = rx_q;
  assign mosi    = lsbf ? tx_q[0] : tx_q[DATA_W-1];

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy_q && $past(busy_q))); // R3
  AST_SCK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && $past(!busy_q) && $stable(cpol)) |-> (sck_q == cpol)); // R4
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spi_master_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned DIV_MIN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  input  logic              ssel_n
);
  localparam int unsigned DIV_W = DATA_W;
  localparam logic [DIV_W-1:0] DIV_FLOOR = DIV_W'(DIV_MIN);

  ctrl_t             ctrl_q;
  logic [DIV_W-1:0]  div_q;
  logic [DATA_W-1:0] rxbuf_q, rx_byte;
  logic              done_f, wcol_f, rovr_f, modf_f;
  logic              seen_xfer, seen_modf, iflag_q;
  logic              busy, done, tick;

  logic wr_ctrl, wr_data, wr_div, wr_iflag, rd_stat, data_acc;
  logic modf_evt, start, abort, collide, clr_xfer;

  assign wr_ctrl  = reg_wr && (reg_addr == RA_CTRL);
  assign wr_data  = reg_wr && (reg_addr == RA_DATA);
  assign wr_div   = reg_wr && (reg_addr == RA_DIV);
  assign wr_iflag = reg_wr && (reg_addr == RA_IFLAG);
  assign rd_stat  = reg_rd && (reg_addr == RA_STAT);
  assign data_acc = (reg_wr || reg_rd) && (reg_addr == RA_DATA);

  assign modf_evt = ctrl_q.master && !ssel_n;
  assign start    = wr_data && ctrl_q.master && !busy && !modf_evt;
  assign abort    = modf_evt || (wr_ctrl && !reg_wdata[CB_MSTR]);
  assign collide  = wr_data && busy;
  assign clr_xfer = data_acc && seen_xfer;

  spi_sck_timer #(.CNT_W(DIV_W-1)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .half (div_q[DIV_W-1:1]),
    .tick (tick)
  );

  spi_shift_core #(.DATA_W(DATA_W)) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .abort  (abort),
    .tx_byte(reg_wdata),
    .cpol   (ctrl_q.cpol),
    .cpha   (ctrl_q.cpha),
    .lsbf   (ctrl_q.lsbf),
    .tick   (tick),
    .miso   (miso),
    .busy   (busy),
    .sck    (sck),
    .mosi   (mosi),
    .rx_byte(rx_byte),
    .done   (done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      div_q     <= DIV_FLOOR;
      rxbuf_q   <= '0;
      done_f    <= 1'b0;
      wcol_f    <= 1'b0;
      rovr_f    <= 1'b0;
      modf_f    <= 1'b0;
      seen_xfer <= 1'b0;
      seen_modf <= 1'b0;
      iflag_q   <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.ie     <= reg_wdata[CB_IE];
        ctrl_q.lsbf   <= reg_wdata[CB_LSBF];
        ctrl_q.master <= reg_wdata[CB_MSTR] && !modf_evt;
        ctrl_q.cpol   <= reg_wdata[CB_CPOL];
        ctrl_q.cpha   <= reg_wdata[CB_CPHA];
      end else if (modf_evt) begin
        ctrl_q.master <= 1'b0;
      end

      if (wr_div)
        div_q <= (reg_wdata < DIV_FLOOR) ? DIV_FLOOR : {reg_wdata[DIV_W-1:1], 1'b0};

      if (done) rxbuf_q <= rx_byte;

      done_f <= (done_f && !clr_xfer) || done;
      wcol_f <= (wcol_f && !clr_xfer) || collide;
      rovr_f <= (rovr_f && !clr_xfer) || (done && done_f && !clr_xfer);

      if (rd_stat && (done_f || wcol_f || rovr_f)) seen_xfer <= 1'b1;
      else if (clr_xfer)                           seen_xfer <= 1'b0;

      modf_f <= (modf_f && !(wr_ctrl && seen_modf)) || modf_evt;
      if (rd_stat && modf_f) seen_modf <= 1'b1;
      else if (wr_ctrl)      seen_modf <= 1'b0;

      iflag_q <= (iflag_q && !(wr_iflag && reg_wdata[0])) || done || modf_evt;
    end
  end

  assign irq = iflag_q && ctrl_q.ie;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL:  reg_rdata = DATA_W'({ctrl_q.ie, ctrl_q.lsbf, ctrl_q.master,
                                     ctrl_q.cpol, ctrl_q.cpha, 3'b000});
      RA_STAT:  reg_rdata = DATA_W'({done_f, wcol_f, rovr_f, modf_f, 4'b0000});
      RA_DATA:  reg_rdata = rxbuf_q;
      RA_DIV:   reg_rdata = div_q;
      RA_IFLAG: reg_rdata = DATA_W'(iflag_q);
      default:  reg_rdata = '0;
    endcase
  end

  AST_WCOL_ON_BUSY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && busy) |=> wcol_f); // R7
  AST_OVERRUN_FROM_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rovr_f) |-> $past(done)); // R8
  AST_MODF_DROPS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    modf_evt |=> (!ctrl_q.master && modf_f && !busy)); // R10
  AST_NO_START_UNMASTERED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.master && !busy) |=> !busy); // R12
endmodule

// File: tb/spi_byte_master_test.sv
module spi_byte_master_test;
  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_DATA = 3'd2,
                         A_DIV  = 3'd3, A_IFLAG = 3'd4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       irq, sck, mosi, miso;
  logic       ssel_n = 1'b1;

  int   checks = 0;
  int   errors = 0;
  bit   finished = 1'b0;

  // bench-side slave model state
  bit        track = 1'b0;
  bit        bcpha = 1'b0, blsbf = 1'b0;
  int        nedge = 0;
  logic [7:0] cap = 8'd0;
  logic [7:0] slave_q = 8'd0;

  always #2 clk = ~clk;

  spi_byte_master uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .sck(sck), .mosi(mosi), .miso(miso), .ssel_n(ssel_n)
  );

  always_comb begin
    int i;
    i = bcpha ? ((nedge == 0) ? 0 : (nedge - 1) / 2) : nedge / 2;
    if (i > 7) i = 7;
    miso = blsbf ? slave_q[i] : slave_q[7 - i];
  end

  always @(sck) begin
    if (track) begin
      if (((nedge % 2) == 0) ^ bcpha)
        cap = blsbf ? {mosi, cap[7:1]} : {cap[6:0], mosi};
      nedge++;
    end
  end

  function automatic int exp_div(input int v);
    int e;
    e = v & 'hFE;
    return (v < 8) ? 8 : e;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk);
    #1 reg_rd = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic arm(input bit cpol, input bit cpha, input bit lsbf,
                     input bit ie, input int divv, input logic [7:0] sl);
    wr(A_CTRL, {ie, lsbf, 1'b1, cpol, cpha, 3'b000});
    wr(A_DIV, 8'(divv));
    bcpha = cpha; blsbf = lsbf;
    @(posedge clk);
    #1 nedge = 0; cap = 8'd0; track = 1'b1; slave_q = sl;
  endtask

  task automatic xfer(input bit cpol, input bit cpha, input bit lsbf, input bit ie,
                      input int divv, input logic [7:0] tx, input logic [7:0] sl);
    logic [7:0] d;
    int h;
    h = exp_div(divv) / 2;
    arm(cpol, cpha, lsbf, ie, divv, sl);
    wr(A_DATA, tx);
    repeat (16 * h) @(posedge clk);
    #1 peek(A_STAT, d);
    chk("R3 complete not yet set", int'(d[7]), 0);
    @(posedge clk);
    #1 peek(A_STAT, d);
    chk("R3 complete set on time", int'(d), 'h80);
    chk("R11 irq follows enable", int'(irq), int'(ie));
    chk("R4 sixteen sck edges", nedge, 16);
    chk("R4 sck back at idle", int'(sck), int'(cpol));
    chk("R5 mosi byte order", int'(cap), int'(tx));
    rd(A_STAT, d);
    rd(A_DATA, d);
    chk("R6 received byte", int'(d), int'(sl));
    peek(A_STAT, d);
    chk("R9 flags cleared", int'(d), 0);
    wr(A_IFLAG, 8'h01);
    #1 chk("R11 flag cleared by one", int'(irq), 0);
    track = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int seed;
    seed = $urandom(32'h5A17);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    peek(A_CTRL, d);  chk("R1 control reset", int'(d), 0);
    peek(A_STAT, d);  chk("R1 status reset", int'(d), 0);
    peek(A_DIV, d);   chk("R1 divider reset", int'(d), 8);
    peek(A_IFLAG, d); chk("R1 iflag reset", int'(d), 0);
    chk("R1 irq low", int'(irq), 0);
    chk("R1 sck low", int'(sck), 0);

    // R2 divider legalisation
    wr(A_DIV, 8'd5);  peek(A_DIV, d); chk("R2 floor of 8", int'(d), 8);
    wr(A_DIV, 8'd13); peek(A_DIV, d); chk("R2 odd rounded down", int'(d), 12);
    wr(A_DIV, 8'd9);  peek(A_DIV, d); chk("R2 nine to eight", int'(d), 8);
    wr(A_DIV, 8'd20); peek(A_DIV, d); chk("R2 even kept", int'(d), 20);

    // directed: all four modes, both orders
    xfer(0, 0, 0, 1, 8,  8'hA5, 8'h3C);
    xfer(0, 1, 1, 0, 10, 8'h81, 8'hE7);
    xfer(1, 0, 1, 1, 12, 8'h0F, 8'h96);
    xfer(1, 1, 0, 0, 9,  8'hC3, 8'h5A);

    // random mix
    for (int k = 0; k < 30; k++) begin
      xfer(1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2),
           int'($urandom % 18), 8'($urandom), 8'($urandom));
    end

    // R7 collision
    arm(0, 0, 0, 0, 8, 8'h81);
    wr(A_DATA, 8'h3C);
    repeat (20) @(posedge clk);
    wr(A_DATA, 8'hFF);
    repeat (16 * 4) @(posedge clk);
    #1 peek(A_STAT, d);
    chk("R7 collision flagged", int'(d), 'hC0);
    chk("R7 mosi byte kept", int'(cap), 'h3C);
    rd(A_STAT, d);
    rd(A_DATA, d);
    chk("R7 received byte kept", int'(d), 'h81);
    peek(A_STAT, d);
    chk("R9 collision cleared", int'(d), 0);
    track = 1'b0;

    // R8 overrun and R9 negative case
    arm(0, 0, 0, 0, 8, 8'h11);
    wr(A_DATA, 8'h22);
    repeat (16 * 4 + 4) @(posedge clk);
    rd(A_DATA, d);
    peek(A_STAT, d);
    chk("R9 data read alone keeps flag", int'(d), 'h80);
    @(posedge clk);
    #1 nedge = 0; cap = 8'd0; slave_q = 8'h77;
    wr(A_DATA, 8'h44);
    repeat (16 * 4 + 4) @(posedge clk);
    #1 peek(A_STAT, d);
    chk("R8 overrun flagged", int'(d), 'hA0);
    rd(A_STAT, d);
    rd(A_DATA, d);
    chk("R8 newest byte kept", int'(d), 'h77);
    peek(A_STAT, d);
    chk("R9 overrun cleared", int'(d), 0);
    track = 1'b0;
    wr(A_IFLAG, 8'h01);

    // R10 mode fault
    arm(1, 0, 0, 1, 8, 8'h00);
    wr(A_DATA, 8'h5A);
    repeat (10) @(posedge clk);
    @(negedge clk) ssel_n = 1'b0;
    @(posedge clk);
    #1 ssel_n = 1'b1;
    repeat (100) @(posedge clk);
    #1 peek(A_STAT, d);
    chk("R10 fault flagged no complete", int'(d), 'h10);
    peek(A_CTRL, d);
    chk("R10 master cleared", int'(d[5]), 0);
    chk("R10 sck idle after abort", int'(sck), 1);
    chk("R11 irq on fault", int'(irq), 1);
    wr(A_CTRL, 8'hB0);
    peek(A_STAT, d);
    chk("R10 fault needs status read", int'(d), 'h10);
    rd(A_STAT, d);
    wr(A_CTRL, 8'hB0);
    peek(A_STAT, d);
    chk("R10 fault cleared", int'(d), 0);
    wr(A_IFLAG, 8'h00);
    #1 chk("R11 write zero no effect", int'(irq), 1);
    wr(A_IFLAG, 8'h01);
    #1 chk("R11 write one clears", int'(irq), 0);
    track = 1'b0;

    // R12 disabled controller and abort by clearing master
    wr(A_CTRL, 8'h00);
    @(posedge clk);
    #1 nedge = 0; track = 1'b1;
    wr(A_DATA, 8'h55);
    repeat (200) @(posedge clk);
    #1 chk("R12 no sck when disabled", nedge, 0);
    peek(A_STAT, d);
    chk("R12 no completion when disabled", int'(d), 0);
    arm(0, 1, 0, 0, 8, 8'h00);
    wr(A_DATA, 8'h99);
    repeat (20) @(posedge clk);
    wr(A_CTRL, 8'h00);
    repeat (100) @(posedge clk);
    #1 peek(A_STAT, d);
    chk("R12 abort leaves no completion", int'(d), 0);
    chk("R12 sck idle after abort", int'(sck), 0);
    track = 1'b0;

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule